// File: doc/BRIEF.md
# Poll-Mode Interrupt Controller

This block gathers a small set of interrupt request lines (timers, DMA channels, external pins) and lets software service them by reading registers instead of running a vectored acknowledge cycle. Each source has its own control word with a 3-bit priority level, a mask bit and a trigger-mode bit. Edge-triggered sources latch a pending bit on a rising request. Level-triggered sources follow their line. A combinational resolver names the winning source: the unmasked pending one with the lowest priority value, with ties going to the lowest source index.

Software reaches the block over a simple single-cycle register bus. Read data is combinational in the cycle where `rdEn` is high. Two read-only words present the same poll state. The status word at offset 0x26 can be read at any time with no effect. The poll word at offset 0x24 returns the same value and, when a request is pending, acknowledges the winner so the next pending request takes its place. A mask view at offset 0x28 collects each source's mask bit. The control words start at offset 0x30, one every two bytes.

Top module: `poll_irq_ctrl`

## Requirements
- R1: After reset every control word reads 0x000F (priority 7, masked, edge mode), the mask view reads all ones in its low NUM_SRC bits, and both poll words read 0x0000.
- R2: The control word of source i sits at 0x30+2*i. Its bits [2:0] hold the priority, bit 3 holds the mask (1 = masked) and bit 4 selects level mode (1 = level, 0 = rising edge). All other bits read zero.
- R3: Bit i of the mask view at 0x28 equals the mask bit of source i's control word, and the bits above NUM_SRC read zero.
- R4: A rising edge on an edge-mode request line makes that source pending after one clock edge. It stays pending after the line falls, until it is acknowledged.
- R5: Each poll word has bit 15 set while a request is pending, bits [4:0] equal to TYPE_BASE plus the winning source index (default TYPE_BASE = 8), and bits [14:5] at zero.
- R6: Among unmasked pending sources the one with the smallest priority value wins, and on equal priority the lower source index wins.
- R7: A masked source still records its request but never wins. Clearing its mask makes the retained request visible.
- R8: Reading the status word at 0x26 changes no pending state.
- R9: Reading the poll word at 0x24 returns the same value as the status word and clears the pending bit of the winning edge-mode source at that clock edge.
- R10: A level-mode source is pending exactly while its line was high at the last clock edge. A poll read does not clear it while the line stays high.
- R11: With nothing pending, a poll-word read returns 0x0000 and acknowledges nothing.
- R12: A rising edge on a source in the same cycle as the poll read that acknowledges that source leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | NUM_SRC | Request lines, one per source |
| rdEn | input | 1 | Read strobe for the current cycle |
| wrEn | input | 1 | Write strobe for the current cycle |
| addr | input | ADDR_W | Byte offset of the accessed register |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data, zero when rdEn is low |

## Verification
The acknowledge of a poll read and the capture of a new rising request can land on the same clock edge, and on the same source. The bench provokes this with a directed case: source 0 is made pending, its line drops, and it rises again in exactly the cycle the poll word is read. A status read then checks that the source is still reported. The random phase drives sparse request pulses under frequent poll reads so that such collisions recur. Every read there is compared with a bench model that applies the new edge after the clear.

// File: rtl/pic_poll_pkg.sv
package pic_poll_pkg;
  localparam int IDX_W = 4;   // up to 16 sources
  localparam int PRI_W = 3;
  localparam int TYPE_W = 5;

  localparam logic [7:0] OFS_POLL   = 8'h24;
  localparam logic [7:0] OFS_STATUS = 8'h26;
  localparam logic [7:0] OFS_MASKV  = 8'h28;
  localparam logic [7:0] OFS_CFG    = 8'h30;

  typedef enum logic [1:0] {SEL_NONE, SEL_POLL, SEL_MASK, SEL_CFG} rdSel_e;

  typedef struct packed {
    logic level;
    logic mask;
    logic [PRI_W-1:0] pri;
  } srcCfg_t;

  typedef struct packed {
    logic ackPoll;
    logic wrCfg;
    logic [IDX_W-1:0] wrIdx;
    rdSel_e rdSel;
    logic [IDX_W-1:0] rdIdx;
  } strobe_t;
endpackage

// File: rtl/pic_poll_ctrl.sv
module pic_poll_ctrl
  import pic_poll_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int ADDR_W  = 8
) (
  input  logic rdEn,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic reqValid,
  output strobe_t strb
);
  logic [ADDR_W-1:0] cfgOff;
  logic cfgHit;

  always_comb begin
    cfgOff = addr - ADDR_W'(OFS_CFG);
    cfgHit = (cfgOff < ADDR_W'(2 * NUM_SRC)) && !cfgOff[0];
    strb = '0;
    strb.rdSel = SEL_NONE;
    strb.rdIdx = IDX_W'(cfgOff >> 1);
    strb.wrIdx = IDX_W'(cfgOff >> 1);
    strb.wrCfg = wrEn && cfgHit;
    if (rdEn) begin
      if (addr == ADDR_W'(OFS_POLL)) begin
        strb.rdSel = SEL_POLL;
        strb.ackPoll = reqValid;
      end else if (addr == ADDR_W'(OFS_STATUS)) begin
        strb.rdSel = SEL_POLL;
      end else if (addr == ADDR_W'(OFS_MASKV)) begin
        strb.rdSel = SEL_MASK;
      end else if (cfgHit) begin
        strb.rdSel = SEL_CFG;
      end
    end
  end
endmodule

// File: rtl/pic_poll_dp.sv
module pic_poll_dp
  import pic_poll_pkg::*;
#(
  parameter int NUM_SRC   = 5,
  parameter int TYPE_BASE = 8,
  parameter int DATA_W    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic [NUM_SRC-1:0] irq,
  input  strobe_t strb,
  input  srcCfg_t wrCfg,
  output logic [DATA_W-1:0] rdData,
  output logic reqValid,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC-1:0] levelVec
);
  localparam int CFG_W = $bits(srcCfg_t);

  srcCfg_t cfg [NUM_SRC];
  logic [NUM_SRC-1:0] irqPrev;
  logic [NUM_SRC-1:0] maskVec;
  logic [IDX_W-1:0] bestIdx;
  logic [PRI_W-1:0] bestPri;
  logic [TYPE_W-1:0] typeCode;
  srcCfg_t cfgRd;

  always_ff @(posedge clk) begin
    if (rst) irqPrev <= '0;
    else     irqPrev <= irq;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[i] <= '{level: 1'b0, mask: 1'b1, pri: '1};
      end else if (strb.wrCfg && strb.wrIdx == IDX_W'(i)) begin
        cfg[i] <= wrCfg;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pendVec[i] <= 1'b0;
      end else if (cfg[i].level) begin
        pendVec[i] <= irq[i];
      end else begin
        pendVec[i] <= (pendVec[i] && !(strb.ackPoll && bestIdx == IDX_W'(i)))
                      || (irq[i] && !irqPrev[i]);
      end
    end

    assign maskVec[i]  = cfg[i].mask;
    assign levelVec[i] = cfg[i].level;
  end

  // winner: lowest priority value, lowest index on ties
  always_comb begin
    reqValid = 1'b0;
    bestIdx  = '0;
    bestPri  = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pendVec[i] && !maskVec[i] && (!reqValid || cfg[i].pri < bestPri)) begin
        reqValid = 1'b1;
        bestIdx  = IDX_W'(i);
        bestPri  = cfg[i].pri;
      end
    end
    typeCode = reqValid ? TYPE_W'(TYPE_BASE) + TYPE_W'(bestIdx) : '0;
  end

  always_comb begin
    cfgRd = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strb.rdIdx == IDX_W'(i)) cfgRd = cfg[i];
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_POLL: rdData = {reqValid, (DATA_W-1-TYPE_W)'(0), typeCode};
      SEL_MASK: rdData = {(DATA_W-NUM_SRC)'(0), maskVec};
      SEL_CFG:  rdData = {(DATA_W-CFG_W)'(0), cfgRd};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/poll_irq_ctrl.sv
module poll_irq_ctrl
  import pic_poll_pkg::*;
#(
  parameter int NUM_SRC   = 5,
  parameter int TYPE_BASE = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic [NUM_SRC-1:0] irq,
  input  logic rdEn,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int CFG_W = $bits(srcCfg_t);

  strobe_t strb;
  logic reqValid;
  logic [NUM_SRC-1:0] pendVec;
  logic [NUM_SRC-1:0] levelVec;
  srcCfg_t wrCfg;
  logic unusedBits;

  assign wrCfg = srcCfg_t'(wrData[CFG_W-1:0]);
  assign unusedBits = ^wrData[DATA_W-1:CFG_W];

  pic_poll_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .reqValid(reqValid), .strb(strb)
  );

  pic_poll_dp #(.NUM_SRC(NUM_SRC), .TYPE_BASE(TYPE_BASE), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .irq(irq), .strb(strb), .wrCfg(wrCfg),
    .rdData(rdData), .reqValid(reqValid), .pendVec(pendVec), .levelVec(levelVec)
  );
endmodule

// File: rtl/poll_irq_ctrl_chk.sv
module poll_irq_ctrl_chk
  import pic_poll_pkg::*;
#(
  parameter int NUM_SRC   = 5,
  parameter int TYPE_BASE = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16
) (
  input logic clk,
  input logic rst,
  input logic [NUM_SRC-1:0] irq,
  input logic rdEn,
  input logic wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [NUM_SRC-1:0] levelVec
);
  logic [NUM_SRC-1:0] irqPrevC;
  logic [NUM_SRC-1:0] riseVec;
  logic [NUM_SRC-1:0] ackMask;
  logic isPoll, isStatus;

  always_ff @(posedge clk) begin
    if (rst) irqPrevC <= '0;
    else     irqPrevC <= irq;
  end

  always_comb begin
    riseVec  = irq & ~irqPrevC;
    isPoll   = rdEn && addr == ADDR_W'(OFS_POLL);
    isStatus = rdEn && addr == ADDR_W'(OFS_STATUS);
    ackMask  = rdData[DATA_W-1]
             ? (NUM_SRC'(1) << (rdData[TYPE_W-1:0] - TYPE_W'(TYPE_BASE))) : '0;
  end

  p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (isPoll || isStatus) |-> rdData[DATA_W-2:TYPE_W] == '0);

  p_idle_type_r11: assert property (@(posedge clk) disable iff (rst)
    ((isPoll || isStatus) && !rdData[DATA_W-1]) |-> rdData[TYPE_W-1:0] == '0);

  p_status_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (isStatus && !wrEn) |=> (($past(pendVec) & ~pendVec & ~levelVec) == '0));

  p_idle_noack_r11: assert property (@(posedge clk) disable iff (rst)
    (isPoll && !rdData[DATA_W-1] && !wrEn)
      |=> (($past(pendVec) & ~pendVec & ~levelVec) == '0));

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (isPoll && rdData[DATA_W-1] && !wrEn && ((ackMask & (levelVec | riseVec)) == '0))
      |=> ((pendVec & $past(ackMask)) == '0));

  p_rise_kept_r12: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && ((riseVec & ~levelVec) != '0))
      |=> (($past(riseVec) & ~$past(levelVec) & ~pendVec) == '0));
endmodule

bind poll_irq_ctrl poll_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .TYPE_BASE(TYPE_BASE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/sim_poll_irq_ctrl.sv
`timescale 1ns/1ps
module sim_poll_irq_ctrl;
  localparam int NS = 5;
  localparam int TB = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] irq = '0;
  logic rdEn = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int mPri [NS];
  bit mMask [NS];
  bit mLvl [NS];
  bit mPend [NS];
  bit mPrev [NS];

  always #2.5 clk = ~clk;

  poll_irq_ctrl u0 (.clk(clk), .rst(rst), .irq(irq), .rdEn(rdEn), .wrEn(wrEn),
                    .addr(addr), .wrData(wrData), .rdData(rdData));

  function automatic int bestSrc();
    int b = -1;
    for (int i = 0; i < NS; i++)
      if (mPend[i] && !mMask[i] && (b < 0 || mPri[i] < mPri[b])) b = i;
    return b;
  endfunction

  function automatic logic [15:0] expRead(input logic [7:0] a);
    int b;
    logic [15:0] v = '0;
    if (a == 8'h24 || a == 8'h26) begin
      b = bestSrc();
      if (b >= 0) v = 16'h8000 | 16'(TB + b);
    end else if (a == 8'h28) begin
      for (int i = 0; i < NS; i++) v[i] = mMask[i];
    end else if (a >= 8'h30 && a < 8'h30 + 2*NS && !a[0]) begin
      b = (a - 8'h30) / 2;
      v = {11'b0, mLvl[b], mMask[b], 3'(mPri[b])};
    end
    return v;
  endfunction

  task automatic modelEdge();
    int b, w;
    if (rst) begin
      for (int i = 0; i < NS; i++) begin
        mPri[i] = 7; mMask[i] = 1; mLvl[i] = 0; mPend[i] = 0; mPrev[i] = 0;
      end
      return;
    end
    b = (rdEn && addr == 8'h24) ? bestSrc() : -1;
    for (int i = 0; i < NS; i++) begin
      if (mLvl[i]) mPend[i] = irq[i];
      else mPend[i] = (mPend[i] && i != b) || (irq[i] && !mPrev[i]);
      mPrev[i] = irq[i];
    end
    if (wrEn && addr >= 8'h30 && addr < 8'h30 + 2*NS && !addr[0]) begin
      w = (addr - 8'h30) / 2;
      mPri[w] = wrData[2:0]; mMask[w] = wrData[3]; mLvl[w] = wrData[4];
    end
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input bit chk, input logic [15:0] exp, input string tag);
    #1;
    if (chk) check(tag, rdData, exp);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    rdEn = 1; wrEn = 0; addr = a;
    tick(1, exp, tag);
    rdEn = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wrEn = 1; rdEn = 0; addr = a; wrData = d;
    tick(0, '0, "");
    wrEn = 0;
  endtask

  task automatic idle();
    tick(0, '0, "");
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    @(negedge clk);
    repeat (3) idle();
    rst = 0;
    // R1 reset state
    rd(8'h26, 16'h0000, "R1 status");
    rd(8'h24, 16'h0000, "R1 poll");
    rd(8'h28, 16'h001F, "R1 maskview");
    rd(8'h30, 16'h000F, "R1 cfg0");
    rd(8'h38, 16'h000F, "R1 cfg4");
    // R2 configure
    wr(8'h30, 16'h0005);
    wr(8'h32, 16'h0002);
    wr(8'h34, 16'h0002);
    wr(8'h36, 16'hFF16);
    wr(8'h38, 16'h0009);
    rd(8'h32, 16'h0002, "R2 cfg1");
    rd(8'h36, 16'h0016, "R2 cfg3 level");
    rd(8'h28, 16'h0010, "R3 maskview");
    // R4/R5 edge latch
    irq = 5'b00001; idle();
    irq = 5'b00000; idle();
    rd(8'h26, 16'h8008, "R4 R5 held after fall");
    // R6/R7 ties and mask
    irq = 5'b10110; idle();
    irq = 5'b00000;
    rd(8'h26, 16'h8009, "R6 tie low index");
    rd(8'h26, 16'h8009, "R8 status repeat");
    rd(8'h24, 16'h8009, "R9 poll value");
    rd(8'h26, 16'h800A, "R9 next after ack");
    rd(8'h24, 16'h800A, "R9 poll src2");
    rd(8'h26, 16'h8008, "R6 masked src4 skipped");
    wr(8'h38, 16'h0001);
    rd(8'h26, 16'h800C, "R7 unmasked retained");
    rd(8'h24, 16'h800C, "R9 poll src4");
    rd(8'h24, 16'h8008, "R9 poll src0");
    rd(8'h26, 16'h0000, "R11 empty status");
    rd(8'h24, 16'h0000, "R11 empty poll");
    rd(8'h26, 16'h0000, "R11 no effect");
    // R10 level source
    irq = 5'b01000; idle();
    rd(8'h26, 16'h800B, "R10 level pending");
    rd(8'h24, 16'h800B, "R10 poll level");
    rd(8'h26, 16'h800B, "R10 not cleared");
    irq = 5'b00000; idle();
    rd(8'h26, 16'h0000, "R10 follows line");
    // R12 rise during ack
    irq = 5'b00001; idle();
    irq = 5'b00000; idle();
    irq = 5'b00001;
    rd(8'h24, 16'h8008, "R12 ack cycle");
    rd(8'h26, 16'h8008, "R12 kept pending");
    rd(8'h24, 16'h8008, "R12 second ack");
    rd(8'h26, 16'h0000, "R12 cleared without rise");
    irq = 5'b00000; idle();
    // random phase against model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      int pick = $urandom_range(0, 9);
      for (int i = 0; i < NS; i++) irq[i] = ($urandom_range(0, 5) == 0) ? ~irq[i] : irq[i];
      case (pick)
        0, 1, 2: a = 8'h24;
        3, 4: a = 8'h26;
        5: a = 8'h28;
        6: a = 8'h30 + 8'(2 * $urandom_range(0, NS - 1));
        default: a = 8'h00;
      endcase
      if (pick == 9 && $urandom_range(0, 3) == 0) begin
        wr(8'h30 + 8'(2 * $urandom_range(0, NS - 1)), 16'($urandom_range(0, 31)));
      end else if (a != 8'h00) begin
        rd(a, expRead(a), a == 8'h24 ? "R9 random poll" :
                          a == 8'h26 ? "R8 random status" :
                          a == 8'h28 ? "R3 random maskview" : "R2 random cfg");
      end else begin
        idle();
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule